// File: doc/BRIEF.md
# Byte-Wide Parallel EEPROM Core

This block is a clocked, synthesizable model of a byte-wide non-volatile memory. It sits behind an asynchronous parallel interface. That interface has three active-low strobes: select, output gate and write strobe. It also has a 13-bit address, an 8-bit bidirectional data bus and a ready line. The three strobes and two digital flags are brought into the system clock domain through synchronizer chains. Strobe edges are detected there. The flags stand in for the high-voltage pin conditions.

A write is requested by a low-going write-strobe pulse while select is low and the output gate is high. The address is taken when the falling edge is detected. The data and the select and gate levels are taken when the rising edge is detected. An internal write then runs for a parameterised number of clock cycles. During that run the ready line is low. The target byte is first set to all ones and then written with the new data.

A read of the byte under write returns the inverted bit 7 of the new data, so a host can poll for completion. Two flags select extra functions. With the address flag set, a 32-byte identification row appears at the top 32 addresses. With the gate flag set, a write-strobe pulse sweeps the main array to all ones and leaves the identification row as it was. The main array depth is a parameter, and the higher address bits alias onto it.

Top module: `nvbyte_core`

## Requirements
- R1: While select is high the block releases the data bus, whatever the output-gate level.
- R2: With select low, output gate low, write strobe high and the gate flag clear, the bus carries the stored byte at the current address.
- R3: A write-strobe pulse taken while select is high, or while the output gate is low, changes no stored byte, and ready stays high.
- R4: A valid write stores the byte present at the rising strobe edge into the address present at the falling edge, and the result equals the new data whatever the byte held before (erase to 0xFF, then program). Ready is low for exactly WR_CYC clock cycles.
- R5: While a write runs, a read of its target returns bit 7 inverted from the new data and bits 6..0 from the byte held before the write. Reads of other addresses return stored data. After ready rises, the target reads as the new data.
- R6: Write-strobe pulses that arrive while a write runs are ignored: no byte changes and the busy length is unaffected.
- R7: With the address flag set, addresses 0x1FE0 to 0x1FFF read and write a separate 32-byte row, indexed by address bits 4..0. With the flag clear, the same addresses reach the main array, where address bits above MAIN_AW-1 are ignored.
- R8: A write-strobe fall with select low and the gate flag set sets every main-array byte to 0xFF, one byte per cycle. Ready is low for 2^MAIN_AW cycles and the identification row keeps its contents.
- R9: If select is high at the rising strobe edge, the pending write is dropped: no byte changes and ready stays high.
- R10: After reset, ready is high and the bus is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_n | input | 1 | Active-low device select (asynchronous) |
| gate_n | input | 1 | Active-low output gate (asynchronous) |
| wstb_n | input | 1 | Active-low write strobe (asynchronous) |
| addr | input | ADDR_W (13) | Byte address |
| dq | inout | 8 | Bidirectional data bus |
| hv_addr_flag | input | 1 | Selects the identification row at the top 32 addresses |
| hv_gate_flag | input | 1 | Turns a write-strobe pulse into a whole-array clear |
| rdy | output | 1 | High when idle, low during an internal write or clear |

## Verification
Two functions can fall in the same cycle: a polled read and a running write. A read of the target address is issued a few cycles after ready falls. The scoreboard expects the inverted new bit 7 joined with the old low bits, and true data once ready returns. A read of another address in the same window must show its stored byte unchanged. A second write pulse is also placed entirely inside a running write. It is judged by the busy length that follows and by the untouched contents of its target.

// File: rtl/nvb_pkg.sv
package nvb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_WRITE = 2'd2,
        ST_CLEAR = 2'd3
    } nvb_state_e;

    localparam int ID_BYTES = 32;
    localparam int ID_AW    = $clog2(ID_BYTES);

    // bit positions inside the synchronised control bundle
    localparam int SB_SEL  = 0;
    localparam int SB_GATE = 1;
    localparam int SB_WSTB = 2;
    localparam int SB_HV9  = 3;
    localparam int SB_HVG  = 4;
    localparam int SB_W    = 5;

endpackage

// File: rtl/nvb_pin_sync.sv
module nvb_pin_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_d;
        logic [STAGES-1:0] chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], din[b]};
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q <= {STAGES{RST_VAL[b]}};
            end else begin
                chain_q <= chain_d;
            end
        end

        assign dout[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/nvb_addr_map.sv
module nvb_addr_map #(
    parameter int ADDR_W  = 13,
    parameter int MAIN_AW = 10
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               id_flag,
    output logic               is_id,
    output logic [MAIN_AW-1:0] idx
);
    import nvb_pkg::*;

    localparam int TOP_W = ADDR_W - ID_AW;

    logic top_ones;

    always_comb begin
        top_ones = &addr[ADDR_W-1:ID_AW];
        is_id    = id_flag && top_ones;
        if (is_id) begin
            idx = MAIN_AW'(addr[ID_AW-1:0]);
        end else begin
            idx = addr[MAIN_AW-1:0];
        end
    end

    if (TOP_W < 1) begin : g_bad_width
        initial $error("address too narrow for the identification row");
    end

endmodule

// File: rtl/nvb_array.sv
module nvb_array #(
    parameter int MAIN_AW = 10
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic                    wr_id,
    input  logic [MAIN_AW-1:0]      wr_idx,
    input  logic [7:0]              wr_data,
    input  logic [1:0]              rd_id,
    input  logic [1:0][MAIN_AW-1:0] rd_idx,
    output logic [1:0][7:0]         rd_data
);
    import nvb_pkg::*;

    localparam int MAIN_DEPTH = 1 << MAIN_AW;

    logic [7:0] main_mem [MAIN_DEPTH];
    logic [7:0] id_mem   [ID_BYTES];

    always_ff @(posedge clk) begin
        if (we) begin
            if (wr_id) begin
                id_mem[wr_idx[ID_AW-1:0]] <= wr_data;
            end else begin
                main_mem[wr_idx] <= wr_data;
            end
        end
    end

    // port 0 serves the bus, port 1 the snapshot of the write target
    for (genvar p = 0; p < 2; p++) begin : g_rd
        assign rd_data[p] = rd_id[p] ? id_mem[rd_idx[p][ID_AW-1:0]]
                                     : main_mem[rd_idx[p]];
    end

endmodule

// File: rtl/nvb_ctrl.sv
module nvb_ctrl #(
    parameter int MAIN_AW = 10,
    parameter int WR_CYC  = 200
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               s_sel_n,
    input  logic               s_gate_n,
    input  logic               s_wstb_n,
    input  logic               s_hvg,
    input  logic               cur_id,
    input  logic [MAIN_AW-1:0] cur_idx,
    input  logic [7:0]         bus_in,
    input  logic [7:0]         cur_data,
    input  logic [7:0]         snap_data,
    output logic               arr_we,
    output logic               arr_wid,
    output logic [MAIN_AW-1:0] arr_widx,
    output logic [7:0]         arr_wdata,
    output logic               lat_id,
    output logic [MAIN_AW-1:0] lat_idx,
    output logic               drive,
    output logic [7:0]         dout,
    output logic               rdy,
    output logic               wfall,
    output logic               wr_active,
    output logic               clr_active
);
    import nvb_pkg::*;

    localparam int MAIN_DEPTH = 1 << MAIN_AW;
    localparam int CNT_W      = $clog2(WR_CYC + 1);
    localparam logic [CNT_W-1:0]   CNT_LAST  = CNT_W'(WR_CYC - 1);
    localparam logic [MAIN_AW-1:0] SWEEP_END = MAIN_AW'(MAIN_DEPTH - 1);

    typedef struct packed {
        nvb_state_e         st;
        logic               wstb_prev;
        logic               lat_id;
        logic [MAIN_AW-1:0] lat_idx;
        logic [7:0]         lat_data;
        logic [7:0]         old_byte;
        logic [CNT_W-1:0]   cnt;
        logic [MAIN_AW-1:0] sweep;
        logic               drive;
        logic [7:0]         dout;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic wrise;
    logic poll_hit;

    always_comb begin
        ctl_d     = ctl_q;
        arr_we    = 1'b0;
        arr_wid   = ctl_q.lat_id;
        arr_widx  = ctl_q.lat_idx;
        arr_wdata = 8'hFF;

        wfall = ctl_q.wstb_prev && !s_wstb_n;
        wrise = !ctl_q.wstb_prev && s_wstb_n;
        ctl_d.wstb_prev = s_wstb_n;

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (wfall && !s_sel_n) begin
                    if (s_hvg) begin
                        ctl_d.st    = ST_CLEAR;
                        ctl_d.sweep = '0;
                    end else if (s_gate_n) begin
                        ctl_d.st      = ST_ARMED;
                        ctl_d.lat_id  = cur_id;
                        ctl_d.lat_idx = cur_idx;
                    end
                end
            end
            ST_ARMED: begin
                if (wrise) begin
                    if (!s_sel_n && s_gate_n && !s_hvg) begin
                        ctl_d.st       = ST_WRITE;
                        ctl_d.lat_data = bus_in;
                        ctl_d.old_byte = snap_data;
                        ctl_d.cnt      = CNT_LAST;
                    end else begin
                        ctl_d.st = ST_IDLE;
                    end
                end
            end
            ST_WRITE: begin
                if (ctl_q.cnt == CNT_LAST) begin
                    arr_we    = 1'b1;
                    arr_wdata = 8'hFF;
                end
                if (ctl_q.cnt == '0) begin
                    arr_we    = 1'b1;
                    arr_wdata = ctl_q.lat_data;
                    ctl_d.st  = ST_IDLE;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_CLEAR: begin
                arr_we    = 1'b1;
                arr_wid   = 1'b0;
                arr_widx  = ctl_q.sweep;
                arr_wdata = 8'hFF;
                if (ctl_q.sweep == SWEEP_END) begin
                    ctl_d.st = ST_IDLE;
                end else begin
                    ctl_d.sweep = ctl_q.sweep + 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase

        poll_hit = (ctl_q.st == ST_WRITE) && (cur_id == ctl_q.lat_id)
                   && (cur_idx == ctl_q.lat_idx);
        ctl_d.dout  = poll_hit ? {~ctl_q.lat_data[7], ctl_q.old_byte[6:0]}
                               : cur_data;
        ctl_d.drive = !s_sel_n && !s_gate_n && s_wstb_n && !s_hvg;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q           <= '0;
            ctl_q.st        <= ST_IDLE;
            ctl_q.wstb_prev <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign lat_id     = ctl_q.lat_id;
    assign lat_idx    = ctl_q.lat_idx;
    assign drive      = ctl_q.drive;
    assign dout       = ctl_q.dout;
    assign wr_active  = (ctl_q.st == ST_WRITE);
    assign clr_active = (ctl_q.st == ST_CLEAR);
    assign rdy        = !(wr_active || clr_active);

endmodule

// File: rtl/nvbyte_core.sv
module nvbyte_core #(
    parameter int ADDR_W      = 13,
    parameter int MAIN_AW     = 10,
    parameter int WR_CYC      = 200,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              gate_n,
    input  logic              wstb_n,
    input  logic [ADDR_W-1:0] addr,
    inout  wire  [7:0]        dq,
    input  logic              hv_addr_flag,
    input  logic              hv_gate_flag,
    output logic              rdy
);
    import nvb_pkg::*;

    localparam logic [SB_W-1:0] SYNC_RST = 5'b00111;

    logic [SB_W-1:0]         pins_raw;
    logic [SB_W-1:0]         pins_s;
    logic                    cur_id;
    logic [MAIN_AW-1:0]      cur_idx;
    logic                    lat_id;
    logic [MAIN_AW-1:0]      lat_idx;
    logic                    arr_we;
    logic                    arr_wid;
    logic [MAIN_AW-1:0]      arr_widx;
    logic [7:0]              arr_wdata;
    logic [1:0]              rd_id;
    logic [1:0][MAIN_AW-1:0] rd_idx;
    logic [1:0][7:0]         rd_data;
    logic                    drive;
    logic [7:0]              dout;
    logic                    wfall;
    logic                    wr_active;
    logic                    clr_active;
    logic [7:0]              bus_in;

    always_comb begin
        pins_raw          = '0;
        pins_raw[SB_SEL]  = sel_n;
        pins_raw[SB_GATE] = gate_n;
        pins_raw[SB_WSTB] = wstb_n;
        pins_raw[SB_HV9]  = hv_addr_flag;
        pins_raw[SB_HVG]  = hv_gate_flag;
    end

    nvb_pin_sync #(
        .WIDTH   (SB_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pins_raw),
        .dout (pins_s)
    );

    nvb_addr_map #(
        .ADDR_W (ADDR_W),
        .MAIN_AW(MAIN_AW)
    ) u_map (
        .addr   (addr),
        .id_flag(pins_s[SB_HV9]),
        .is_id  (cur_id),
        .idx    (cur_idx)
    );

    assign rd_id     = {lat_id, cur_id};
    assign rd_idx[0] = cur_idx;
    assign rd_idx[1] = lat_idx;

    nvb_array #(
        .MAIN_AW(MAIN_AW)
    ) u_array (
        .clk    (clk),
        .we     (arr_we),
        .wr_id  (arr_wid),
        .wr_idx (arr_widx),
        .wr_data(arr_wdata),
        .rd_id  (rd_id),
        .rd_idx (rd_idx),
        .rd_data(rd_data)
    );

    assign bus_in = dq;

    nvb_ctrl #(
        .MAIN_AW(MAIN_AW),
        .WR_CYC (WR_CYC)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_sel_n   (pins_s[SB_SEL]),
        .s_gate_n  (pins_s[SB_GATE]),
        .s_wstb_n  (pins_s[SB_WSTB]),
        .s_hvg     (pins_s[SB_HVG]),
        .cur_id    (cur_id),
        .cur_idx   (cur_idx),
        .bus_in    (bus_in),
        .cur_data  (rd_data[0]),
        .snap_data (rd_data[1]),
        .arr_we    (arr_we),
        .arr_wid   (arr_wid),
        .arr_widx  (arr_widx),
        .arr_wdata (arr_wdata),
        .lat_id    (lat_id),
        .lat_idx   (lat_idx),
        .drive     (drive),
        .dout      (dout),
        .rdy       (rdy),
        .wfall     (wfall),
        .wr_active (wr_active),
        .clr_active(clr_active)
    );

    assign dq = drive ? dout : 8'hzz;

endmodule

// File: rtl/nvb_checker.sv
module nvb_checker #(
    parameter int WR_CYC  = 200,
    parameter int MAIN_AW = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               s_sel_n,
    input logic               drive,
    input logic               rdy,
    input logic               wr_active,
    input logic               clr_active,
    input logic               arr_we,
    input logic               arr_wid,
    input logic [7:0]         arr_wdata,
    input logic               wfall,
    input logic [MAIN_AW-1:0] lat_idx
);
    localparam int LEN_W = $clog2(WR_CYC + 2);

    logic [LEN_W-1:0] wlen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wlen_q <= '0;
        end else if (wr_active) begin
            wlen_q <= wlen_q + 1'b1;
        end else begin
            wlen_q <= '0;
        end
    end

    p_standby_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        s_sel_n |=> !drive);

    p_write_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_active) |-> (wlen_q == LEN_W'(WR_CYC)));

    p_quiet_when_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |-> !arr_we);

    p_busy_ignores_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_active && wfall) |=> $stable(lat_idx));

    p_clear_main_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_active && arr_we) |-> (!arr_wid && arr_wdata == 8'hFF));

endmodule

bind nvbyte_core nvb_checker #(
    .WR_CYC (WR_CYC),
    .MAIN_AW(MAIN_AW)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_sel_n   (pins_s[0]),
    .drive     (drive),
    .rdy       (rdy),
    .wr_active (wr_active),
    .clr_active(clr_active),
    .arr_we    (arr_we),
    .arr_wid   (arr_wid),
    .arr_wdata (arr_wdata),
    .wfall     (wfall),
    .lat_idx   (lat_idx)
);

// File: tb/nvbyte_core_tb_top.sv
`timescale 1ns/1ps
module nvbyte_core_tb_top;

    localparam int T_MAIN_AW = 8;
    localparam int T_WR_CYC  = 40;
    localparam int T_DEPTH   = 1 << T_MAIN_AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1;
    logic        gate_n = 1'b1;
    logic        wstb_n = 1'b1;
    logic [12:0] addr = '0;
    logic        hv9 = 1'b0;
    logic        hvg = 1'b0;
    logic        tb_en = 1'b0;
    logic [7:0]  tb_val = '0;
    logic        rdy;
    wire  [7:0]  dq;

    assign dq = tb_en ? tb_val : 8'hzz;

    always #2 clk = ~clk;   // 250 MHz

    nvbyte_core #(
        .ADDR_W (13),
        .MAIN_AW(T_MAIN_AW),
        .WR_CYC (T_WR_CYC)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_n       (sel_n),
        .gate_n      (gate_n),
        .wstb_n      (wstb_n),
        .addr        (addr),
        .dq          (dq),
        .hv_addr_flag(hv9),
        .hv_gate_flag(hvg),
        .rdy         (rdy)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // scoreboard: expected bytes queued by the driver, compared by the monitor
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] obs;
    event       smp_ev;

    initial begin
        forever begin
            @(smp_ev);
            if (exp_q.size() == 0) begin
                chk("scoreboard underflow", 1, 0);
            end else begin
                chk(tag_q.pop_front(), int'(obs), int'(exp_q.pop_front()));
            end
        end
    end

    // busy-run tracker: length of the last completed low stretch of rdy
    int runs = 0;
    int last_len = 0;
    int cur_len = 0;
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !rdy) begin
                cur_len++;
            end else if (cur_len != 0) begin
                last_len = cur_len;
                runs++;
                cur_len = 0;
            end
        end
    end

    task automatic pulse(input logic [12:0] a, input logic [7:0] d, input bit h9,
                         input bit hg, input bit sel_fall_n, input bit gate_lvl,
                         input bit sel_rise_n);
        @(negedge clk);
        addr = a; hv9 = h9; hvg = hg;
        sel_n = sel_fall_n; gate_n = gate_lvl;
        tb_val = d; tb_en = gate_lvl;
        repeat (4) @(negedge clk);
        wstb_n = 1'b0;
        repeat (5) @(negedge clk);
        sel_n = sel_rise_n;
        repeat (4) @(negedge clk);
        wstb_n = 1'b1;
        repeat (5) @(negedge clk);
        sel_n = 1'b1; gate_n = 1'b1; tb_en = 1'b0; hv9 = 1'b0; hvg = 1'b0;
    endtask

    task automatic rd(input logic [12:0] a, input bit h9, input logic [7:0] e,
                      input string tag);
        @(negedge clk);
        tb_en = 1'b0; addr = a; hv9 = h9; sel_n = 1'b0; gate_n = 1'b0;
        repeat (6) @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        obs = dq;
        ->smp_ev;
        @(negedge clk);
        sel_n = 1'b1; gate_n = 1'b1; hv9 = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic standby_chk(input logic [12:0] a, input string tag);
        @(negedge clk);
        addr = a; hv9 = 1'b0; sel_n = 1'b1; gate_n = 1'b0;
        tb_val = 8'h5A; tb_en = 1'b1;
        repeat (6) @(negedge clk);
        exp_q.push_back(8'h5A);
        tag_q.push_back(tag);
        obs = dq;
        ->smp_ev;
        @(negedge clk);
        gate_n = 1'b1; tb_en = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_idle();
        repeat (3) @(negedge clk);
        while (!rdy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk("watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        int r0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10 ready after reset", int'(rdy), 1);

        // R8: full clear brings the main array to a known state
        r0 = runs;
        pulse(13'h0000, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        wait_idle();
        chk("R8 clear busy length", last_len, T_DEPTH);
        chk("R8 one busy run", runs - r0, 1);
        rd(13'h0005, 1'b0, 8'hFF, "R8 cleared byte low");
        rd(13'h00FF, 1'b0, 8'hFF, "R8 cleared byte high");

        // R7: identification row versus aliased main location
        pulse(13'h1FE3, 8'h3C, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        wait_idle();
        pulse(13'h1FE3, 8'hA5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        wait_idle();
        rd(13'h1FE3, 1'b1, 8'h3C, "R7 id row read");
        rd(13'h1FE3, 1'b0, 8'hA5, "R7 main array at top address");
        rd(13'h00E3, 1'b0, 8'hA5, "R7 main alias");

        // R1 / R10: standby releases the bus with the gate low
        standby_chk(13'h1FE3, "R1 bus released in standby");

        // R4: write, rewrite with data needing erase, busy length
        r0 = runs;
        pulse(13'h0010, 8'h12, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        wait_idle();
        chk("R4 busy length", last_len, T_WR_CYC);
        pulse(13'h0010, 8'h81, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        wait_idle();
        chk("R4 two busy runs", runs - r0, 2);
        rd(13'h0010, 1'b0, 8'h81, "R4 rewrite replaces old byte");
        rd(13'h0011, 1'b0, 8'hFF, "R2 neighbour untouched");

        // R5: polling during the self-timed write
        pulse(13'h0020, 8'h55, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        wait_idle();
        pulse(13'h0020, 8'h43, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R5 busy seen", int'(rdy), 0);
        rd(13'h0020, 1'b0, 8'hD5, "R5 polled target");
        rd(13'h0010, 1'b0, 8'h81, "R5 other address while busy");
        wait_idle();
        rd(13'h0020, 1'b0, 8'h43, "R5 true data after ready");

        // R6: pulse inside a running write is ignored
        r0 = runs;
        pulse(13'h0030, 8'h11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        pulse(13'h0031, 8'h22, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        wait_idle();
        chk("R6 single busy run", runs - r0, 1);
        chk("R6 busy length unchanged", last_len, T_WR_CYC);
        rd(13'h0031, 1'b0, 8'hFF, "R6 ignored target");
        rd(13'h0030, 1'b0, 8'h11, "R6 first write kept");

        // R3: inhibited pulses
        r0 = runs;
        pulse(13'h0040, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        pulse(13'h0041, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        repeat (10) @(negedge clk);
        chk("R3 no busy", runs - r0, 0);
        rd(13'h0040, 1'b0, 8'hFF, "R3 gate low inhibits");
        rd(13'h0041, 1'b0, 8'hFF, "R3 select high inhibits");

        // R9: select released before the rising edge
        r0 = runs;
        pulse(13'h0042, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        repeat (10) @(negedge clk);
        chk("R9 no busy", runs - r0, 0);
        rd(13'h0042, 1'b0, 8'hFF, "R9 aborted write");

        // R8: second clear spares the identification row
        pulse(13'h0000, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        wait_idle();
        chk("R8 second clear length", last_len, T_DEPTH);
        rd(13'h0010, 1'b0, 8'hFF, "R8 main byte cleared");
        rd(13'h1FE3, 1'b0, 8'hFF, "R8 aliased byte cleared");
        rd(13'h1FE3, 1'b1, 8'h3C, "R8 id row kept");

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule